// File: doc/BRIEF.md
# Receive Sample Phase Tuning Sweep

This block picks a receive sample delay for the host side of a storage card link. A one-cycle start request begins a sweep over every value of a small phase code, from zero upward. For each value the block writes the code into a field of a 32-bit timing control register, leaving the register's other bits unchanged. It then waits a fixed settle interval and clears the pending interrupt status. After that it asks an external command engine to run one tuning transfer and waits for that transfer's pass or fail result.

From the results it finds the first run of passing codes and takes the midpoint of that run. A failure after the run has started ends the sweep at once. A run that is still open at the highest code ends there. The block writes the chosen code into the register, waits the settle interval again and clears the interrupts a final time. It then pulses done. If no code passes, the block applies code zero and raises an error flag. The chosen code and the error flag stay on the outputs until the next sweep decides new ones.

Top module: `phase_tune_ctrl`

## Requirements
- R1: After reset, ctrl_wr_o, int_clr_o, tune_req_o, done_o and err_o are 0, and phase_o is 0.
- R2: Starting from an idle controller, a start pulse begins a sweep that visits codes 0, 1, 2, … in increasing order. Each visit starts with a one-cycle ctrl_wr_o. During that cycle, ctrl_wdata_o equals ctrl_base_i with bits 20..16 replaced by the code and every other bit copied from ctrl_base_i.
- R3: After each register write, including the final one, the block waits exactly SETTLE_CYC cycles with no clear, no request and no write.
- R4: In the cycle after the settle interval, int_clr_o is high for one cycle and int_clr_mask_o reads 0x1FFFF. This clear comes before each tuning request and again after the final write.
- R5: tune_req_o rises in the cycle after the clear. It stays high until the cycle in which tune_done_i is high, and tune_pass_i is sampled in that cycle. A tune_done_i pulse while tune_req_o is low has no effect.
- R6: The first passing code becomes the window start. The first failing code after a start ends the sweep with no further codes tried, and the window end is that code minus 1. The applied code is (start+end)/2, with the result truncated.
- R7: If the highest code (31) is reached with no failure after a start, the window end is 31. This includes a first pass at code 31, which gives start = end = 31.
- R8: If no code passes, the final write carries code 0, err_o is 1 and phase_o is 0. A sweep that finds a window sets err_o to 0.
- R9: done_o is high for one cycle, in the cycle after the final clear. phase_o and err_o change only in the cycle of the final register write. A start_i while a sweep is running, or in the done cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Sweep request pulse, honoured only when idle |
| ctrl_base_i | input | 32 | Current value of the timing control register |
| ctrl_wr_o | output | 1 | Register write strobe |
| ctrl_wdata_o | output | 32 | Register write data, with the phase code placed in bits 20..16 |
| int_clr_o | output | 1 | Interrupt status clear strobe |
| int_clr_mask_o | output | 17 | Clear mask, 0x1FFFF while int_clr_o is high |
| tune_req_o | output | 1 | Tuning transfer request, held until its result arrives |
| tune_done_i | input | 1 | Transfer finished pulse |
| tune_pass_i | input | 1 | Transfer result, 1 means pass, valid with tune_done_i |
| done_o | output | 1 | One-cycle end-of-sweep pulse |
| phase_o | output | 5 | Last applied result code |
| err_o | output | 1 | Set when no code passed in the last sweep |

## Verification
The bench builds the block with SETTLE_CYC = 3 and keeps the phase width at 5. This makes a full 32-code sweep that never passes short enough to run in a few hundred cycles, alongside windows that close early, windows still open at code 31, and a single pass at 0x1F. The result latency varies with the code, from one to three cycles, so the request-hold rule is tested at several depths. Two sweeps add stray done pulses and start requests during the settle intervals and the done cycle to show that the block ignores them.

// File: rtl/phase_tune_pkg.sv
package phase_tune_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SET,
    ST_SETTLE,
    ST_CLR,
    ST_REQ,
    ST_FSET,
    ST_FSETTLE,
    ST_FCLR,
    ST_DONE
  } state_e;
endpackage

// File: rtl/phase_tune_field.sv
module phase_tune_field #(
  parameter int REG_W     = 32,
  parameter int FIELD_LSB = 16,
  parameter int PHASE_W   = 5
) (
  input  logic [REG_W-1:0]   base_i,
  input  logic [PHASE_W-1:0] code_i,
  output logic [REG_W-1:0]   data_o
);
  localparam logic [REG_W-1:0] FIELD_MASK = REG_W'({PHASE_W{1'b1}}) << FIELD_LSB;

  always_comb begin
    data_o = (base_i & ~FIELD_MASK) | (REG_W'(code_i) << FIELD_LSB);
  end
endmodule

// File: rtl/phase_tune_timer.sv
module phase_tune_timer #(
  parameter int CYC = 100000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic expired_o
);
  localparam int CNT_W = $clog2(CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= CNT_W'(CYC - 1);
    else if (cnt_q != '0)     cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expired_o = (cnt_q == '0);

  if (CYC > 1) begin : g_chk
    // R3
    settle_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> !expired_o);
  end
endmodule

// File: rtl/phase_tune_window.sv
module phase_tune_window #(
  parameter int PHASE_W = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               eval_i,
  input  logic               pass_i,
  input  logic [PHASE_W-1:0] code_i,
  output logic               stop_o,
  output logic               none_o,
  output logic [PHASE_W-1:0] final_o
);
  localparam int SUM_W = PHASE_W + 1;
  localparam logic [PHASE_W-1:0] LAST = '1;

  logic               have_q;
  logic [PHASE_W-1:0] start_q;
  logic [PHASE_W-1:0] s_eff, e_val;
  logic [SUM_W-1:0]   sum;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      have_q  <= 1'b0;
      start_q <= '0;
    end else if (clr_i) begin
      have_q  <= 1'b0;
      start_q <= '0;
    end else if (eval_i && pass_i && !have_q) begin
      have_q  <= 1'b1;
      start_q <= code_i;
    end
  end

  always_comb begin
    stop_o = 1'b0;
    none_o = 1'b0;
    s_eff  = start_q;
    e_val  = LAST;
    if (have_q && !pass_i) begin
      stop_o = 1'b1;
      e_val  = code_i - PHASE_W'(1);
    end else if (code_i == LAST) begin
      stop_o = 1'b1;
      if (!have_q) begin
        s_eff  = code_i;
        none_o = !pass_i;
      end
    end
    sum     = {1'b0, s_eff} + {1'b0, e_val};
    final_o = none_o ? '0 : sum[SUM_W-1:1];
  end

  // R6
  win_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eval_i && stop_o && !none_o |-> final_o <= code_i);
endmodule

// File: rtl/phase_tune_ctrl.sv
module phase_tune_ctrl
  import phase_tune_pkg::*;
#(
  parameter int REG_W      = 32,
  parameter int PHASE_W    = 5,
  parameter int FIELD_LSB  = 16,
  parameter int INT_W      = 17,
  parameter logic [INT_W-1:0] CLR_MASK = '1,
  parameter int SETTLE_CYC = 100000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [REG_W-1:0]   ctrl_base_i,
  output logic               ctrl_wr_o,
  output logic [REG_W-1:0]   ctrl_wdata_o,
  output logic               int_clr_o,
  output logic [INT_W-1:0]   int_clr_mask_o,
  output logic               tune_req_o,
  input  logic               tune_done_i,
  input  logic               tune_pass_i,
  output logic               done_o,
  output logic [PHASE_W-1:0] phase_o,
  output logic               err_o
);
  state_e             state_q, state_d;
  logic [PHASE_W-1:0] code_q, phase_q, wr_code, win_final;
  logic               err_q;
  logic               tmr_load, tmr_exp;
  logic               win_clr, win_eval, win_stop, win_none;

  assign win_clr  = (state_q == ST_IDLE) && start_i;
  assign win_eval = (state_q == ST_REQ) && tune_done_i;
  assign tmr_load = (state_q == ST_SET) || (state_q == ST_FSET);

  phase_tune_timer #(.CYC(SETTLE_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (tmr_load),
    .expired_o(tmr_exp)
  );

  phase_tune_window #(.PHASE_W(PHASE_W)) u_window (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (win_clr),
    .eval_i (win_eval),
    .pass_i (tune_pass_i),
    .code_i (code_q),
    .stop_o (win_stop),
    .none_o (win_none),
    .final_o(win_final)
  );

  assign wr_code = (state_q == ST_FSET) ? phase_q : code_q;

  phase_tune_field #(
    .REG_W    (REG_W),
    .FIELD_LSB(FIELD_LSB),
    .PHASE_W  (PHASE_W)
  ) u_field (
    .base_i(ctrl_base_i),
    .code_i(wr_code),
    .data_o(ctrl_wdata_o)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (start_i) state_d = ST_SET;
      ST_SET:     state_d = ST_SETTLE;
      ST_SETTLE:  if (tmr_exp) state_d = ST_CLR;
      ST_CLR:     state_d = ST_REQ;
      ST_REQ:     if (tune_done_i) state_d = win_stop ? ST_FSET : ST_SET;
      ST_FSET:    state_d = ST_FSETTLE;
      ST_FSETTLE: if (tmr_exp) state_d = ST_FCLR;
      ST_FCLR:    state_d = ST_DONE;
      ST_DONE:    state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      code_q  <= '0;
      phase_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (win_clr) code_q <= '0;
      else if (win_eval && !win_stop) code_q <= code_q + PHASE_W'(1);
      if (win_eval && win_stop) begin
        phase_q <= win_final;
        err_q   <= win_none;
      end
    end
  end

  assign ctrl_wr_o      = (state_q == ST_SET) || (state_q == ST_FSET);
  assign int_clr_o      = (state_q == ST_CLR) || (state_q == ST_FCLR);
  assign int_clr_mask_o = int_clr_o ? CLR_MASK : '0;
  assign tune_req_o     = (state_q == ST_REQ);
  assign done_o         = (state_q == ST_DONE);
  assign phase_o        = phase_q;
  assign err_o          = err_q;

  // R5
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tune_req_o && !tune_done_i |=> tune_req_o);
  // R4
  clr_next_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_clr_o |=> tune_req_o || done_o);
  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  result_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(phase_o) || !$stable(err_o) |-> ctrl_wr_o);
  // R8
  err_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && err_o |-> phase_o == '0);
endmodule

// File: tb/phase_tune_ctrl_bench.sv
module phase_tune_ctrl_bench;
  localparam int S = 3;

  typedef struct packed {
    logic        wr;
    logic [31:0] wd;
    logic        clr;
    logic        req;
    logic        dn;
    logic [4:0]  ph;
    logic        er;
    logic        st;
    logic        din;
    logic        pin;
    logic [1:0]  k;
  } ent_t;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [31:0] ctrl_base_i = '0;
  logic        tune_done_i = 1'b0;
  logic        tune_pass_i = 1'b0;
  logic        ctrl_wr_o, int_clr_o, tune_req_o, done_o, err_o;
  logic [31:0] ctrl_wdata_o;
  logic [16:0] int_clr_mask_o;
  logic [4:0]  phase_o;

  int errors = 0;
  int checks = 0;
  logic [4:0] prev_ph = '0;
  logic       prev_er = 1'b0;
  ent_t q[$];

  always #2.5 clk = ~clk;

  phase_tune_ctrl #(.SETTLE_CYC(S)) u_phase_tune_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .ctrl_base_i(ctrl_base_i),
    .ctrl_wr_o(ctrl_wr_o), .ctrl_wdata_o(ctrl_wdata_o), .int_clr_o(int_clr_o),
    .int_clr_mask_o(int_clr_mask_o), .tune_req_o(tune_req_o),
    .tune_done_i(tune_done_i), .tune_pass_i(tune_pass_i), .done_o(done_o),
    .phase_o(phase_o), .err_o(err_o)
  );

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic ent_t mk();
    ent_t e;
    e = '0;
    e.ph = prev_ph;
    e.er = prev_er;
    return e;
  endfunction

  function automatic logic [31:0] mrg(input logic [31:0] b, input int c);
    return (b & ~32'h001F_0000) | (32'(c) << 16);
  endfunction

  task automatic play();
    ent_t e;
    string tcl, tph;
    while (q.size() > 0) begin
      e = q.pop_front();
      @(negedge clk);
      tcl = (e.k == 2'd1) ? "R3" : "R4";
      tph = (e.k == 2'd2) ? "R7" : "R6";
      chk(ctrl_wr_o === e.wr, (e.k == 2'd1) ? "R3" : "R2", 32'(ctrl_wr_o), 32'(e.wr));
      if (e.wr) chk(ctrl_wdata_o === e.wd, "R2", ctrl_wdata_o, e.wd);
      chk(int_clr_o === e.clr, tcl, 32'(int_clr_o), 32'(e.clr));
      if (e.clr) chk(int_clr_mask_o === 17'h1FFFF, "R4", 32'(int_clr_mask_o), 32'h1FFFF);
      chk(tune_req_o === e.req, (e.k == 2'd1) ? "R3" : "R5", 32'(tune_req_o), 32'(e.req));
      chk(done_o === e.dn, "R9", 32'(done_o), 32'(e.dn));
      chk(phase_o === e.ph, tph, 32'(phase_o), 32'(e.ph));
      chk(err_o === e.er, "R8", 32'(err_o), 32'(e.er));
      start_i     = e.st;
      tune_done_i = e.din;
      tune_pass_i = e.pin;
    end
  endtask

  task automatic run(input logic [31:0] mask, input logic [31:0] base, input bit spur);
    ent_t e;
    int s, en, d;
    bit stopped;
    logic [1:0] fk;
    s = -1; en = -1; stopped = 0;
    ctrl_base_i = base;
    q.delete();
    e = mk(); e.st = 1'b1; q.push_back(e);
    for (int c = 0; c < 32; c++) begin
      e = mk(); e.wr = 1'b1; e.wd = mrg(base, c); q.push_back(e);
      for (int k = 0; k < S; k++) begin
        e = mk(); e.k = 2'd1;
        if (spur) begin e.st = 1'b1; e.din = 1'b1; e.pin = 1'b1; end
        q.push_back(e);
      end
      e = mk(); e.clr = 1'b1; q.push_back(e);
      d = 1 + (c % 3);
      for (int k = 0; k < d; k++) begin
        e = mk(); e.req = 1'b1;
        if (k == d - 1) begin e.din = 1'b1; e.pin = mask[c]; end
        q.push_back(e);
      end
      if (mask[c] && s < 0) s = c;
      else if (!mask[c] && s >= 0) begin en = c - 1; stopped = 1; break; end
    end
    fk = stopped ? 2'd0 : 2'd2;
    if (!stopped) en = 31;
    if (s < 0) begin prev_ph = '0; prev_er = 1'b1; end
    else begin prev_ph = 5'((s + en) / 2); prev_er = 1'b0; end
    e = mk(); e.k = fk; e.wr = 1'b1; e.wd = mrg(base, int'(prev_ph)); q.push_back(e);
    for (int k = 0; k < S; k++) begin
      e = mk(); e.k = 2'd1;
      if (spur) begin e.st = 1'b1; e.din = 1'b1; end
      q.push_back(e);
    end
    e = mk(); e.k = fk; e.clr = 1'b1; q.push_back(e);
    e = mk(); e.k = fk; e.dn = 1'b1; e.st = spur; q.push_back(e);
    e = mk(); e.k = fk; q.push_back(e);
    e = mk(); e.k = fk; q.push_back(e);
    play();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({ctrl_wr_o, int_clr_o, tune_req_o, done_o, err_o} === 5'b0, "R1",
        32'({ctrl_wr_o, int_clr_o, tune_req_o, done_o, err_o}), 32'h0);
    chk(phase_o === 5'd0, "R1", 32'(phase_o), 32'h0);
    run(32'h0000_03E0, 32'hA5A5_A5A5, 1'b0); // window 5..9 -> 7
    run(32'hFFFF_FFFF, 32'h0000_0000, 1'b1); // open to 31 -> 15
    run(32'h0000_0000, 32'hFFFF_FFFF, 1'b0); // none -> err
    run(32'h8000_0000, 32'h1234_5678, 1'b0); // only 31
    run(32'h0000_0008, 32'h00E0_0001, 1'b0); // single 3
    run(32'h0000_005C, 32'h5A5A_0F0F, 1'b1); // 2..4, later pass unseen -> 3
    run(32'hC000_0000, 32'h001F_0000, 1'b0); // 30..31 -> 30
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule